// File: doc/BRIEF.md
# Configurable-Framing Serial Transmitter

This block sends characters over a single asynchronous serial line. A producer writes a character into a one-entry holding stage with a load strobe. As soon as the frame shifter is free, the character moves into the shifter, and the holding stage can take the next character. The shifter sends a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. Character length, parity style and stop length are set by configuration inputs.

All bit timing comes from a tick that runs at sixteen times the bit rate. The tick comes from dividing the system clock by a 16-bit divisor. The divisor counter restarts at the first edge of each frame, so every bit lasts exactly 16 times the divisor in clock cycles. Two status outputs are provided. One says the holding stage can accept a character. The other says that nothing is pending and nothing is on the line.

Top module: `uart_tx_frame`

## Requirements
- R1: After a synchronous active-low reset, `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1.
- R2: A frame starts with one start bit at 0, followed by `cfg_chlen`+5 data bits sent least significant bit first (`cfg_chlen` 0→5, 1→6, 2→7, 3→8 bits). Each bit lasts 16 ticks, which is 16×`cfg_div` clock cycles.
- R3: `cfg_par` selects the parity bit that follows the data: 0 even, 1 odd, 2 always 0, 3 always 1, and 4 to 7 no parity bit. Even and odd parity count only the selected data bits.
- R4: `cfg_stop` selects the high stop period: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks. `tx_empty` rises at the clock edge that ends the stop period when no character is pending.
- R5: While `cfg_div` is 0, no tick is produced, no frame starts and `txd` stays 1. A pending character starts one clock after `cfg_div` becomes nonzero.
- R6: A strobe on `ld_valid` while `tx_ready` is 1 captures `ld_data`, and `tx_ready` reads 0 after that edge. When the shifter is idle, the character starts on the next edge, and `tx_ready` returns to 1 at that edge.
- R7: A strobe on `ld_valid` while `tx_ready` is 0 is ignored, and the character already held is the one that is sent.
- R8: When a character is pending at the end of a stop period, its start bit begins at that same edge. No idle time is inserted and `tx_empty` stays 0.
- R9: Character length, parity and stop length are sampled when a frame starts. Changing them during the frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 16 | Clock divisor for the 16x tick; 0 stops the tick |
| cfg_chlen | input | 2 | Character length code |
| cfg_par | input | 3 | Parity style code |
| cfg_stop | input | 2 | Stop length code |
| ld_valid | input | 1 | Load strobe for the holding stage |
| ld_data | input | 8 | Character to load |
| txd | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Holding stage can accept a character |
| tx_empty | output | 1 | Nothing pending and the line is idle |

## Verification
The bench uses the default parameters: a 16-bit divisor, 16 ticks per bit and a 5-bit minimum character. Divisors of 1 to 3 keep frames short. That lets every character length, all eight parity codes, all four stop codes and back-to-back frames be checked at the middle of each bit and at the exact closing edge. The divisor-zero case and a mid-frame change of configuration are also within reach.

// File: rtl/uart_tx_pkg.sv
// Shared types and codes for the serial transmitter.
// Assumes the parity and stop codes listed in the brief.
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_t;

    localparam logic [2:0] PAR_EVEN = 3'd0;
    localparam logic [2:0] PAR_ODD  = 3'd1;
    localparam logic [2:0] PAR_ZERO = 3'd2;
    localparam logic [2:0] PAR_ONE  = 3'd3;

    localparam logic [1:0] STOP_ONE      = 2'd0;
    localparam logic [1:0] STOP_ONE_HALF = 2'd1;
endpackage

// File: rtl/uart_tick_gen.sv
// Oversampling tick generator.
// Produces a single-cycle tick every `div` clocks. A divisor of 0 produces no tick.
// `restart` zeroes the count so that a new frame starts on a full tick period.
module uart_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             div_nz;

    assign div_nz = |div;
    assign tick   = div_nz && (cnt >= div - 1'b1);

    // Count clocks between ticks; wrap on a tick or on a frame restart.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else if (div_nz)          cnt <= cnt + 1'b1;
    end

    // R2: with a divisor above 1 held steady, two ticks are never adjacent
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > 1) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/uart_hold_reg.sv
// One-entry holding stage.
// Captures a character when empty, ignores writes while full,
// and empties when the shifter takes the character.
module uart_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Track occupancy and capture data only into an empty stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    // R7: a full stage keeps its character until it is taken
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(data)));
    // R6: the shifter only takes from a full stage
    a_r6_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);
endmodule

// File: rtl/uart_frame_shift.sv
// Frame shifter: start, data LSB first, optional parity, stop.
// Assumes that `tick` comes at OVS times the bit rate and that `take` is only
// asserted while `can_take` is high. Frame settings are latched on `take`.
module uart_frame_shift
    import uart_tx_pkg::*;
#(
    parameter int MIN_BITS = 5,
    parameter int OVS      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    take,
    input  logic [MIN_BITS+2:0]     din,
    input  logic [1:0]              chlen,
    input  logic [2:0]              par_mode,
    input  logic [1:0]              stop_mode,
    output logic                    can_take,
    output logic                    busy,
    output logic                    txd
);
    localparam int DATA_W = MIN_BITS + 3;
    localparam int TCNT_W = $clog2(2 * OVS);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam logic [TCNT_W-1:0] BIT_LAST  = TCNT_W'(OVS - 1);
    localparam logic [TCNT_W-1:0] HALF_LAST = TCNT_W'(OVS + OVS / 2 - 1);
    localparam logic [TCNT_W-1:0] TWO_LAST  = TCNT_W'(2 * OVS - 1);

    tx_state_t         state;
    logic [TCNT_W-1:0] tcnt;
    logic [TCNT_W-1:0] stop_last;
    logic [TCNT_W-1:0] cur_last;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_en;
    logic              par_bit;
    logic              at_last;
    logic              nxt_par_bit;
    logic [IDX_W-1:0]  nxt_last_idx;

    assign cur_last = (state == ST_STOP) ? stop_last : BIT_LAST;
    assign at_last  = (tcnt == cur_last);
    assign busy     = (state != ST_IDLE);
    assign can_take = !busy || (state == ST_STOP && tick && at_last);
    assign nxt_last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(chlen);

    // Parity over the selected data bits only, shaped by the parity style.
    always_comb begin
        logic ones;
        ones = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i <= int'(nxt_last_idx)) ones = ones ^ din[i];
        end
        case (par_mode)
            PAR_EVEN: nxt_par_bit = ones;
            PAR_ODD:  nxt_par_bit = ~ones;
            PAR_ZERO: nxt_par_bit = 1'b0;
            default:  nxt_par_bit = 1'b1;
        endcase
    end

    // Frame sequencer: latch settings on take, advance one bit per OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            idx       <= '0;
            last_idx  <= '0;
            shreg     <= '0;
            par_en    <= 1'b0;
            par_bit   <= 1'b0;
            stop_last <= BIT_LAST;
        end else if (take) begin
            state     <= ST_START;
            tcnt      <= '0;
            idx       <= '0;
            last_idx  <= nxt_last_idx;
            shreg     <= din;
            par_en    <= (par_mode <= PAR_ONE);
            par_bit   <= nxt_par_bit;
            stop_last <= (stop_mode == STOP_ONE)      ? BIT_LAST :
                         (stop_mode == STOP_ONE_HALF) ? HALF_LAST : TWO_LAST;
        end else if (tick && busy) begin
            if (!at_last) begin
                tcnt <= tcnt + 1'b1;
            end else begin
                tcnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        idx   <= idx + 1'b1;
                        if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Line level for the current frame position.
    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    // R2: position in the frame only moves on a tick or a new frame
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !take) |=> ($stable(state) && $stable(tcnt)));
    // R2: inside a bit the tick count steps by one per tick
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && !take && !at_last) |=> (tcnt == $past(tcnt) + 1'b1));
endmodule

// File: rtl/uart_tx_frame.sv
// Top level of the serial transmitter: tick generator, holding stage and frame
// shifter. A pending character moves to the shifter when the shifter is idle or
// finishing its stop period and the divisor is nonzero.
module uart_tx_frame #(
    parameter int DIV_W    = 16,
    parameter int MIN_BITS = 5,
    parameter int OVS      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic [1:0]           cfg_chlen,
    input  logic [2:0]           cfg_par,
    input  logic [1:0]           cfg_stop,
    input  logic                 ld_valid,
    input  logic [MIN_BITS+2:0]  ld_data,
    output logic                 txd,
    output logic                 tx_ready,
    output logic                 tx_empty
);
    localparam int DATA_W = MIN_BITS + 3;

    logic              tick;
    logic              go;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              can_take;
    logic              busy;

    assign go       = hold_full && (|cfg_div) && can_take;
    assign tx_ready = !hold_full;
    assign tx_empty = !hold_full && !busy;

    uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (cfg_div),
        .restart (go),
        .tick    (tick)
    );

    uart_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_valid),
        .wr_data (ld_data),
        .take    (go),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_frame_shift #(.MIN_BITS(MIN_BITS), .OVS(OVS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .take      (go),
        .din       (hold_data),
        .chlen     (cfg_chlen),
        .par_mode  (cfg_par),
        .stop_mode (cfg_stop),
        .can_take  (can_take),
        .busy      (busy),
        .txd       (txd)
    );

    // R2: every frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !txd);
    // R5: a zero divisor keeps an idle line idle and high
    a_r5_idle_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div == '0 && !busy) |=> (!busy && txd));
    // R8: a frame started at the end of a stop period keeps the shifter busy
    a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go) |=> busy);
endmodule

// File: tb/tb_uart_tx_frame.sv
module tb_uart_tx_frame;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_div = 16'd1;
    logic [1:0]  cfg_chlen = 2'd3;
    logic [2:0]  cfg_par = 3'd4;
    logic [1:0]  cfg_stop = 2'd0;
    logic        ld_valid = 1'b0;
    logic [7:0]  ld_data = 8'h00;
    logic        txd, tx_ready, tx_empty;

    int n_chk = 0;
    int n_bad = 0;
    int t = 0;
    bit reported = 0;

    always #5 clk = ~clk;

    uart_tx_frame dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_chlen(cfg_chlen),
        .cfg_par(cfg_par), .cfg_stop(cfg_stop), .ld_valid(ld_valid),
        .ld_data(ld_data), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at t=%0d", req, what, act, exp, t);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    // Advance to negedge number `target` after the frame's start edge.
    task automatic adv(input int target);
        while (t < target) begin
            @(negedge clk);
            t++;
        end
    endtask

    function automatic int exp_par(input logic [7:0] d, input int len, input int par);
        int ones = 0;
        for (int i = 0; i < len + 5; i++) ones += d[i];
        case (par)
            0: return ones % 2;
            1: return 1 - (ones % 2);
            2: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int stop_ticks(input int stop);
        return (stop == 0) ? 16 : (stop == 1) ? 24 : 32;
    endfunction

    // Check one frame; t must be 0 at the negedge after its start edge.
    task automatic verify_frame(input logic [7:0] d, input int len, input int par,
                                input int stop, input int div, output int tend);
        int nd = len + 5;
        int np = (par <= 3) ? 1 : 0;
        int p;
        adv(8 * div);
        chk(txd == 1'b0, "R2", "start bit", txd, 0);
        for (int i = 0; i < nd; i++) begin
            adv(16 * div * (1 + i) + 8 * div);
            chk(txd == d[i], "R2", "data bit", txd, d[i]);
        end
        if (np == 1) begin
            adv(16 * div * (1 + nd) + 8 * div);
            chk(txd == exp_par(d, len, par), "R3", "parity bit", txd, exp_par(d, len, par));
        end
        p = 1 + nd + np;
        adv(16 * div * p + 8 * div);
        chk(txd == 1'b1, "R4", "stop level", txd, 1);
        tend = 16 * div * p + stop_ticks(stop) * div;
        adv(tend - 1);
        chk(txd == 1'b1 && tx_empty == 1'b0, "R4", "stop still running", tx_empty, 0);
        adv(tend);
    endtask

    // Load a character into an idle transmitter; returns with t=0 after start edge.
    task automatic load_idle(input logic [7:0] d);
        ld_valid = 1'b1;
        ld_data  = d;
        @(negedge clk);
        ld_valid = 1'b0;
        chk(tx_ready == 1'b0, "R6", "ready low after capture", tx_ready, 0);
        @(negedge clk);
        t = 0;
        chk(tx_ready == 1'b1 && txd == 1'b0, "R6", "moved to shifter", tx_ready, 1);
    endtask

    task automatic set_cfg(input int div, input int len, input int par, input int stop);
        cfg_div   = 16'(div);
        cfg_chlen = 2'(len);
        cfg_par   = 3'(par);
        cfg_stop  = 2'(stop);
    endtask

    task automatic single(input logic [7:0] d, input int div, input int len,
                          input int par, input int stop, input bit scramble);
        int tend;
        set_cfg(div, len, par, stop);
        load_idle(d);
        if (scramble) begin
            // R9: settings change after the frame started
            cfg_chlen = ~cfg_chlen;
            cfg_par   = 3'(par + 3);
            cfg_stop  = ~cfg_stop;
        end
        verify_frame(d, len, par, stop, div, tend);
        chk(tx_empty == 1'b1 && txd == 1'b1, "R4", "empty at stop end", tx_empty, 1);
        set_cfg(div, len, par, stop);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    initial begin
        int tend;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk(txd == 1'b1, "R1", "txd idle", txd, 1);
        chk(tx_ready == 1'b1, "R1", "ready", tx_ready, 1);
        chk(tx_empty == 1'b1, "R1", "empty", tx_empty, 1);

        // R2: 8-bit, no parity, one stop
        single(8'hA5, 2, 3, 4, 0, 0);
        // R3: parity counts only 5 bits; R4: 1.5 stop bits
        single(8'hFF, 1, 0, 0, 1, 0);
        single(8'h3C, 1, 1, 1, 2, 0);
        single(8'h00, 2, 2, 3, 0, 0);
        single(8'h7F, 1, 3, 2, 3, 0);
        // R3: code 6 means no parity bit
        single(8'h96, 3, 2, 6, 1, 0);

        // R5: divisor zero holds the character back
        set_cfg(0, 3, 4, 0);
        ld_valid = 1'b1;
        ld_data  = 8'h5A;
        @(negedge clk);
        ld_valid = 1'b0;
        repeat (100) @(negedge clk);
        chk(txd == 1'b1, "R5", "line high with zero divisor", txd, 1);
        chk(tx_ready == 1'b0 && tx_empty == 1'b0, "R5", "character pending", tx_ready, 0);
        cfg_div = 16'd1;
        @(negedge clk);
        t = 0;
        chk(txd == 1'b0, "R5", "start after divisor set", txd, 0);
        verify_frame(8'h5A, 3, 4, 0, 1, tend);
        chk(tx_empty == 1'b1, "R5", "empty after frame", tx_empty, 1);
        @(negedge clk);

        // R7 and R8: queue a second character, try a third, run back to back
        set_cfg(1, 3, 0, 0);
        load_idle(8'hC3);
        ld_valid = 1'b1;
        ld_data  = 8'h1E;
        adv(1);
        ld_valid = 1'b0;
        chk(tx_ready == 1'b0, "R6", "second queued", tx_ready, 0);
        ld_valid = 1'b1;
        ld_data  = 8'hFF;
        adv(2);
        ld_valid = 1'b0;
        verify_frame(8'hC3, 3, 0, 0, 1, tend);
        chk(txd == 1'b0, "R8", "next start at stop end", txd, 0);
        chk(tx_empty == 1'b0, "R8", "empty stays low", tx_empty, 0);
        chk(tx_ready == 1'b1, "R8", "ready after move", tx_ready, 1);
        t = 0;
        verify_frame(8'h1E, 3, 0, 0, 1, tend);
        chk(tx_empty == 1'b1, "R7", "ignored write never sent", tx_empty, 1);
        @(negedge clk);

        // R9 plus random framing
        for (int k = 0; k < 40; k++) begin
            int div  = 1 + int'($urandom_range(2));
            int len  = int'($urandom_range(3));
            int par  = int'($urandom_range(7));
            int stop = int'($urandom_range(3));
            logic [7:0] d = 8'($urandom);
            single(d, div, len, par, stop, (k % 2) == 1);
        end

        report();
        $finish;
    end
endmodule